// File: doc/BRIEF.md
# Successive Approximation Conversion Controller

This block holds the code register and the sequencing for a successive approximation analog-to-digital converter. A conversion begins when `start` is seen high on a rising clock edge while the block is idle. The block then spends one cycle clearing its code register. After that it tests one bit per clock, from the most significant bit down to the least significant bit. For each test it places a trial code on `dac_code` for an external DAC. It then reads a single comparator decision, `cmp_ge`, which says whether the held analog input is at or above the DAC output.

An N-bit conversion uses exactly N comparisons, not the 2^N a linear search would need. Together with the clearing cycle it takes exactly N+1 clocks. When the last decision is made, the result is latched and `done` pulses for one cycle. The DAC code then keeps showing the final result until the next conversion starts.

The DAC, the comparator and the sample-and-hold stage are outside this block. The control pins `start`, `busy` and `done` are plain levels and pulses. The result bus has no back-pressure: a consumer must take `result` in the `done` cycle or at any later point before the next `done`, because the block never stalls waiting for it. A `start` seen while a conversion is running is dropped, not queued.

Top module: `sar_adc_ctrl`

## Requirements
- R1: After reset, `busy`, `done`, `result` and `dac_code` are all zero.
- R2: When `start` is high at a rising edge while idle, `busy` is high in the next cycle and `dac_code` is zero during that one clearing cycle.
- R3: In the first trial cycle, which follows the clearing cycle, `dac_code` has only bit N-1 set.
- R4: In the trial for bit i, `dac_code` carries the bits already decided above i, a 1 at bit i, and zeros below i. Bit i is kept at 1 when `cmp_ge` is 1 at the edge that ends the trial, and cleared when it is 0.
- R5: `busy` stays high for exactly N+1 consecutive cycles. `done` is high for exactly one cycle, the first cycle after `busy` falls, and is never high together with `busy`.
- R6: With an ideal DAC and comparator against a held input value v in the range 0 to 2^N-1, `result` equals v.
- R7: A `start` seen at any edge while `busy` is high has no effect: the conversion's trial codes, its length and its result are unchanged.
- R8: While idle, `dac_code` equals `result` and both hold their values until the next conversion.
- R9: A `start` seen at the edge that ends the `done` cycle begins a new conversion, so `busy` is high again in the very next cycle with `dac_code` zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; every action happens on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to convert; sampled on each rising edge, acted on only when idle |
| cmp_ge | input | 1 | Comparator decision: 1 when the held input is at or above the DAC output |
| dac_code | output | N | Trial code sent to the external DAC; holds the last result when idle |
| result | output | N | Latched conversion result |
| busy | output | 1 | High during the clearing cycle and all N trial cycles |
| done | output | 1 | One-cycle pulse in the cycle after the last decision |

## Verification
The `start` edge sets `busy`, and `dac_code` reads zero one cycle later. The first trial code then appears in the cycle after that. Each later trial code appears one cycle after the decision before it. `result`, `done` and the falling `busy` all appear together, N+1 cycles after the `start` edge. The bench drives all inputs and samples all outputs on the falling clock edge. It walks the conversion one cycle at a time and compares each trial code with the code expected for that exact cycle, computed from the held input value. After `busy` falls it checks `done` and `result` in that same cycle, and checks in the cycle after that the value still holds.

// File: rtl/sar_pkg.sv
package sar_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_CLR   = 2'd1,
    PH_TRIAL = 2'd2
  } phase_t;
endpackage

// File: rtl/sar_seq.sv
module sar_seq #(
  parameter int N = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output sar_pkg::phase_t   phase,
  output logic [IW-1:0]     idx,
  output logic              done
);
  import sar_pkg::*;

  localparam logic [IW-1:0] TOP_IDX = IW'(N - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      idx   <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (phase)
        PH_IDLE: if (start) phase <= PH_CLR;
        PH_CLR: begin
          phase <= PH_TRIAL;
          idx   <= TOP_IDX;
        end
        PH_TRIAL: begin
          if (idx == '0) begin
            phase <= PH_IDLE;
            done  <= 1'b1;
          end else begin
            idx <= idx - 1'b1;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  // R2: the clearing phase lasts one cycle and hands over to the MSB trial
  p_clr_one_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    phase == PH_CLR |=> (phase == PH_TRIAL && idx == TOP_IDX));

  // R5: done only follows the LSB decision
  p_done_after_lsb_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(phase == PH_TRIAL && idx == '0));

  // R7: start while running never restarts the clearing phase
  p_start_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_IDLE && start) |=> phase != PH_CLR);
endmodule

// File: rtl/sar_code.sv
module sar_code #(
  parameter int N = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  sar_pkg::phase_t   phase,
  input  logic [IW-1:0]     idx,
  input  logic              cmp_ge,
  output logic [N-1:0]      code,
  output logic [N-1:0]      result
);
  import sar_pkg::*;

  localparam logic [N-1:0] MSB_ONLY = {1'b1, {(N-1){1'b0}}};

  logic [N-1:0]  trial_next;
  logic [IW-1:0] idx_below;

  always_comb begin
    idx_below  = idx - 1'b1;
    trial_next = code;
    trial_next[idx] = cmp_ge;
    if (idx != '0) trial_next[idx_below] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code   <= '0;
      result <= '0;
    end else begin
      unique case (phase)
        PH_IDLE:  if (launch) code <= '0;
        PH_CLR:   code <= MSB_ONLY;
        PH_TRIAL: begin
          code <= trial_next;
          if (idx == '0) result <= trial_next;
        end
        default: code <= code;
      endcase
    end
  end

  // R4: a trial never disturbs bits already decided above it
  p_upper_bits_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    phase == PH_TRIAL |=>
      ((code ^ $past(code)) >> (int'($past(idx)) + 1)) == '0);

  // R8: idle without a launch keeps code and result steady
  p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IDLE && !launch) |=> ($stable(code) && $stable(result)));
endmodule

// File: rtl/sar_adc_ctrl.sv
module sar_adc_ctrl #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         cmp_ge,
  output logic [N-1:0] dac_code,
  output logic [N-1:0] result,
  output logic         busy,
  output logic         done
);
  import sar_pkg::*;

  localparam int IW = (N > 1) ? $clog2(N) : 1;

  phase_t        phase;
  logic [IW-1:0] idx;
  logic          launch;

  assign launch = (phase == PH_IDLE) && start;
  assign busy   = (phase != PH_IDLE);

  sar_seq #(.N(N)) u_seq (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .phase (phase),
    .idx   (idx),
    .done  (done)
  );

  sar_code #(.N(N)) u_code (
    .clk    (clk),
    .rst_n  (rst_n),
    .launch (launch),
    .phase  (phase),
    .idx    (idx),
    .cmp_ge (cmp_ge),
    .code   (dac_code),
    .result (result)
  );

  // R5: done and busy are never high together
  p_busy_done_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({busy, done}));

  // R8: in the done cycle the DAC is already showing the latched result
  p_done_shows_result_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (dac_code == result));

  // R2: an accepted start makes the next cycle busy with a cleared code
  p_launch_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> (busy && dac_code == '0));
endmodule

// File: tb/sar_adc_ctrl_tb.sv
module sar_adc_ctrl_tb;
  localparam int N = 8;
  localparam int MAXV = (1 << N) - 1;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic         cmp_ge;
  logic [N-1:0] dac_code, result;
  logic         busy, done;
  logic [N-1:0] vin = '0;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  // ideal DAC plus comparator against the held input
  assign cmp_ge = (vin >= dac_code);

  sar_adc_ctrl #(.N(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .cmp_ge(cmp_ge),
    .dac_code(dac_code), .result(result), .busy(busy), .done(done)
  );

  function automatic logic [N-1:0] trial_code(input logic [N-1:0] v, input int bit_i);
    logic [N-1:0] upper_mask;
    upper_mask = ~((N'(1) << (bit_i + 1)) - N'(1));
    if (bit_i == N - 1) upper_mask = '0;
    return (v & upper_mask) | (N'(1) << bit_i);
  endfunction

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // run one conversion; mid_at >= 0 pulses start during that busy cycle
  task automatic convert(input logic [N-1:0] v, input int mid_at, input logic hold);
    int cyc;
    vin = v;
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    if (!hold) start = 1'b0;
    cyc = 0;
    while (busy && cyc < 4 * N) begin
      if (cyc == 0)
        chk(dac_code == '0, "R2 clear cycle code", dac_code, 0);
      else if (cyc == 1)
        chk(dac_code == trial_code(v, N - 1), "R3 msb trial", dac_code, trial_code(v, N - 1));
      else
        chk(dac_code == trial_code(v, N - cyc), "R4 trial code", dac_code, trial_code(v, N - cyc));
      if (!hold) start = (cyc == mid_at);
      cyc++;
      @(negedge clk);
    end
    if (!hold) start = 1'b0;
    chk(cyc == N + 1, "R5 busy length", cyc, N + 1);
    chk(done == 1'b1, "R5 done after busy", done, 1);
    chk(result == v, "R6 result", result, v);
    if (mid_at >= 0)
      chk(result == v && cyc == N + 1, "R7 mid start ignored", result, v);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'h5A17);
    repeat (3) @(negedge clk);
    chk(busy == 1'b0 && done == 1'b0, "R1 reset busy/done", {busy, done}, 0);
    chk(result == '0 && dac_code == '0, "R1 reset data", result | dac_code, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // directed corners
    convert('0, -1, 1'b0);
    convert(N'(MAXV), -1, 1'b0);
    convert(N'(1), -1, 1'b0);
    convert(N'(1 << (N - 1)), -1, 1'b0);
    convert(N'((1 << (N - 1)) - 1), 3, 1'b0);

    // R8: idle holds result on the DAC
    @(negedge clk);
    chk(done == 1'b0, "R5 done single cycle", done, 0);
    repeat (3) @(negedge clk);
    chk(dac_code == result && result == N'((1 << (N - 1)) - 1), "R8 idle hold", dac_code, result);

    // R7: start held high for the whole run, R9: back-to-back restart
    convert(N'(8'hA5), -1, 1'b1);
    vin = N'(8'h3C);
    @(negedge clk);
    chk(busy == 1'b1 && dac_code == '0, "R9 back to back restart", {busy, dac_code}, 1 << N);
    start = 1'b0;
    while (busy) @(negedge clk);
    chk(done == 1'b1 && result == N'(8'h3C), "R9 second result", result, 8'h3C);

    // random inputs, some with a mid-conversion start
    for (int k = 0; k < 40; k++) begin
      logic [N-1:0] rv;
      int mid;
      rv = N'($urandom_range(0, MAXV));
      mid = ($urandom_range(0, 3) == 0) ? int'($urandom_range(0, N)) : -1;
      repeat ($urandom_range(0, 2)) @(negedge clk);
      convert(rv, mid, 1'b0);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule